// File: doc/BRIEF.md
# SMBus Block Transfer Data Buffer

This block is the byte store behind SMBus block reads and block writes in an SMBus host controller. Software moves a whole block through one data port: every access to that port touches the entry under an internal pointer, and the pointer then steps to the next entry. A read of the host control offset returns the pointer to entry 0, so software can rewind before it loads a write payload or drains a read payload. The transfer length sits in the data-0 count register, not in the buffer. Software writes it before a block write, and the bus engine writes the count it received during a block read.

An enable bit in the auxiliary control register selects buffer mode. When the bit is clear, the data port is a single holding register at entry 0 and the pointer does not move. The serial bus engine connects on a second side. It rewinds its own pointer with a start pulse, pops transmit bytes or pushes received bytes from entry 0 upward, and sees the effective length together with last-byte and done flags, so that it moves exactly as many bytes as the count allows.

Top module: `smb_blk_buf`

## Requirements
- R1: After reset the count register reads 0, the auxiliary register reads 0 (buffer mode off), every buffer entry holds 0, and the effective length is 1.
- R2: Bit 1 of the auxiliary register (offset 13) is the buffer-mode enable. A write sets it from write-data bit 1, and it reads back in bit 1. All other bits of that register read 0.
- R3: In buffer mode each write to the data port (offset 7) stores the byte at the pointer, and each read returns the entry at the pointer. Each access, read or write, advances the pointer by one.
- R4: The software pointer saturates at entry DEPTH-1. Further accesses read or overwrite that last entry and leave the other entries unchanged.
- R5: Any read of the host control offset (offset 2) sets the software pointer to entry 0. That read returns 0 from this block.
- R6: The count register (data 0, offset 5) is written and read by software. A count update from the engine loads the same register and wins over a software write in the same cycle.
- R7: With buffer mode off the data port is one holding register at entry 0. A read returns the last byte written, and no access moves the pointer.
- R8: After an engine start pulse, each pop in buffer mode returns entries 0, 1, 2 and so on. The last flag is high exactly while the byte at position length-1 is presented, and the done flag rises after length pops and stays high through further pops.
- R9: After an engine start pulse, each push in buffer mode stores its byte at entries 0, 1, 2 and so on. Pushes after length bytes are dropped and change no entry.
- R10: The effective length presented to the engine is the count clamped to the range 1..DEPTH: a count of 0 gives 1, and a count above DEPTH gives DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW (4) | Register offset of the software access |
| reg_wr | input | 1 | Software write strobe |
| reg_rd | input | 1 | Software read strobe (side effects only) |
| reg_wdata | input | 8 | Software write data |
| reg_rdata | output | 8 | Read data for the addressed offset (combinational) |
| eng_start | input | 1 | Engine pointer rewind to entry 0 |
| eng_pop | input | 1 | Engine consumes the byte on eng_tx_data |
| eng_push | input | 1 | Engine stores eng_rx_data |
| eng_rx_data | input | 8 | Byte received from the bus |
| eng_tx_data | output | 8 | Byte at the engine pointer |
| eng_cnt_we | input | 1 | Engine loads the count register |
| eng_cnt_val | input | 8 | Count received from the target |
| eng_len | output | LEN_W (6) | Clamped transfer length |
| eng_last | output | 1 | Current engine byte is the final one |
| eng_done | output | 1 | Length bytes have been moved since start |

## Verification
A pointer that slips or sticks does not fail at the moment it goes wrong. It shows up at the next data-port read as a byte from a neighbouring entry, so the bench sweeps every entry against a model array after each fill. A wrong engine position or length shows up on the same pop as a mismatched byte or as the last or done flag in the wrong cycle. The bench checks this for every length from 1 to DEPTH. A dropped-push fault stays hidden until software drains the buffer, so each receive run ends with a full readback.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

  localparam int OFS_HCTL = 2;
  localparam int OFS_CNT  = 5;
  localparam int OFS_PORT = 7;
  localparam int OFS_AUX  = 13;
  localparam int AUX_BUF_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HCTL,
    SEL_CNT,
    SEL_PORT,
    SEL_AUX
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int ofs);
    case (ofs)
      OFS_HCTL: return SEL_HCTL;
      OFS_CNT:  return SEL_CNT;
      OFS_PORT: return SEL_PORT;
      OFS_AUX:  return SEL_AUX;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Clamp a byte count into the legal transfer range 1..depth.
  function automatic int blk_len(input int cnt, input int depth);
    if (cnt < 1) return 1;
    if (cnt > depth) return depth;
    return cnt;
  endfunction

endpackage

// File: rtl/smb_blk_ptr.sv
module smb_blk_ptr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic [W-1:0] val
);

  logic room;
  assign room = (val < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else if (clr) val <= '0;
    else if (adv && room) val <= val + W'(1);
  end

  AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val == '0)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && (val < lim)) |=> (val == $past(val) + W'(1))); // R3
  AST_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (val >= lim)) |=> (val == $past(val))); // R4

endmodule

// File: rtl/smb_blk_store.sv
module smb_blk_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [DW-1:0]    sw_d,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [DW-1:0]    eng_d,
  output logic [DW-1:0]    sw_q,
  output logic [DW-1:0]    eng_q
);

  logic [DW-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_eng, hit_sw;
    assign hit_eng = eng_we && (eng_idx == IDX_W'(e));
    assign hit_sw  = sw_we  && (sw_idx  == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[e] <= '0;
      else if (hit_eng) mem[e] <= eng_d;
      else if (hit_sw) mem[e] <= sw_d;
    end
  end

  assign sw_q  = mem[sw_idx];
  assign eng_q = mem[eng_idx];

  AST_ENG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> (mem[$past(eng_idx)] == $past(eng_d))); // R9
  AST_SW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !(eng_we && eng_idx == sw_idx)) |=> (mem[$past(sw_idx)] == $past(sw_d))); // R3

endmodule

// File: rtl/smb_blk_regs.sv
module smb_blk_regs
  import smb_blk_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  input  logic          eng_cnt_we,
  input  logic [DW-1:0] eng_cnt_val,
  input  logic [DW-1:0] port_q,
  output logic [DW-1:0] count,
  output logic          buf_en,
  output logic          port_acc,
  output logic          port_wr,
  output logic          hctl_rd,
  output logic          cfg_wr,
  output logic [DW-1:0] reg_rdata
);

  reg_sel_e sel;
  assign sel = decode_ofs(int'(reg_addr));

  assign port_wr  = reg_wr && (sel == SEL_PORT);
  assign port_acc = (reg_wr || reg_rd) && (sel == SEL_PORT);
  assign hctl_rd  = reg_rd && (sel == SEL_HCTL);
  assign cfg_wr   = eng_cnt_we || (reg_wr && (sel == SEL_CNT || sel == SEL_AUX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (eng_cnt_we) count <= eng_cnt_val;
    else if (reg_wr && sel == SEL_CNT) count <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_en <= 1'b0;
    else if (reg_wr && sel == SEL_AUX) buf_en <= reg_wdata[AUX_BUF_BIT];
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CNT:  reg_rdata = count;
      SEL_PORT: reg_rdata = port_q;
      SEL_AUX:  reg_rdata[AUX_BUF_BIT] = buf_en;
      default:  reg_rdata = '0;
    endcase
  end

  AST_CNT_ENG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cnt_we |=> (count == $past(eng_cnt_val))); // R6
  AST_AUX_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_AUX) |=> (buf_en == $past(reg_wdata[AUX_BUF_BIT]))); // R2

endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf
  import smb_blk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             eng_start,
  input  logic             eng_pop,
  input  logic             eng_push,
  input  logic [DW-1:0]    eng_rx_data,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_cnt_we,
  input  logic [DW-1:0]    eng_cnt_val,
  output logic [LEN_W-1:0] eng_len,
  output logic             eng_last,
  output logic             eng_done
);

  logic [DW-1:0]    count;
  logic             buf_en, port_acc, port_wr, hctl_rd, cfg_wr;
  logic [DW-1:0]    port_q;
  logic [IDX_W-1:0] sw_val, sw_idx, eng_idx;
  logic [LEN_W-1:0] eng_val;
  logic             sw_adv, eng_adv, eng_we;

  smb_blk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .eng_cnt_we(eng_cnt_we), .eng_cnt_val(eng_cnt_val),
    .port_q(port_q), .count(count), .buf_en(buf_en),
    .port_acc(port_acc), .port_wr(port_wr), .hctl_rd(hctl_rd), .cfg_wr(cfg_wr),
    .reg_rdata(reg_rdata)
  );

  assign sw_adv = port_acc && buf_en;

  smb_blk_ptr #(.W(IDX_W)) u_sw_ptr (
    .clk(clk), .rst_n(rst_n), .clr(hctl_rd), .adv(sw_adv),
    .lim(IDX_W'(DEPTH - 1)), .val(sw_val)
  );

  assign eng_len = LEN_W'(blk_len(int'(count), DEPTH));
  assign eng_adv = (eng_pop || eng_push) && buf_en;

  smb_blk_ptr #(.W(LEN_W)) u_eng_ptr (
    .clk(clk), .rst_n(rst_n), .clr(eng_start), .adv(eng_adv),
    .lim(eng_len), .val(eng_val)
  );

  assign eng_done = buf_en && (eng_val == eng_len);
  assign eng_last = buf_en ? (eng_val == eng_len - LEN_W'(1)) : 1'b1;
  assign sw_idx   = buf_en ? sw_val : '0;
  assign eng_idx  = buf_en ? eng_val[IDX_W-1:0] : '0;
  assign eng_we   = eng_push && !eng_done;

  smb_blk_store #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sw_we(port_wr), .sw_idx(sw_idx), .sw_d(reg_wdata),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_d(eng_rx_data),
    .sw_q(port_q), .eng_q(eng_tx_data)
  );

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && port_acc && !hctl_rd) |=> (sw_val == $past(sw_val))); // R7
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_start && !cfg_wr) |=> eng_done); // R8
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_len >= LEN_W'(1)) && (eng_len <= LEN_W'(DEPTH))); // R10

endmodule

// File: tb/smb_blk_buf_test.sv
`timescale 1ns/1ps
module smb_blk_buf_test;

  localparam int DEPTH = 32;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic eng_start = 0, eng_pop = 0, eng_push = 0, eng_cnt_we = 0;
  logic [7:0] eng_rx_data = '0, eng_tx_data, eng_cnt_val = '0;
  logic [LEN_W-1:0] eng_len;
  logic eng_last, eng_done;

  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  smb_blk_buf uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_pop(eng_pop), .eng_push(eng_push), .eng_rx_data(eng_rx_data),
    .eng_tx_data(eng_tx_data), .eng_cnt_we(eng_cnt_we), .eng_cnt_val(eng_cnt_val),
    .eng_len(eng_len), .eng_last(eng_last), .eng_done(eng_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic estart();
    @(negedge clk); eng_start = 1;
    @(negedge clk); eng_start = 0;
  endtask

  function automatic int pat(input int i, input int s);
    return (i * s + 11) & 255;
  endfunction

  function automatic int exp_len(input int c);
    return (c == 0) ? 1 : ((c > DEPTH) ? DEPTH : c);
  endfunction

  task automatic drain_check(input string req);
    rd(2, rv);
    for (int i = 0; i < DEPTH; i++) begin
      rd(7, rv);
      chk(req, rv, mdl[i]);
    end
  endtask

  initial begin
    #20000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(13, rv); chk("R1", rv, 0);
    rd(5, rv);  chk("R1", rv, 0);
    rd(7, rv);  chk("R1", rv, 0);
    chk("R1", eng_len, 1);

    // R2 aux enable bit
    wr(13, 8'hFF); rd(13, rv); chk("R2", rv, 8'h02);
    wr(13, 8'hFD); rd(13, rv); chk("R2", rv, 8'h00);
    wr(13, 8'h02); rd(13, rv); chk("R2", rv, 8'h02);

    // R3 fill and drain, R5 rewind reads 0
    rd(2, rv); chk("R5", rv, 0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(7, pat(i, 37)); mdl[i] = 8'(pat(i, 37));
    end
    drain_check("R3");

    // R4 saturation at last entry
    rd(7, rv); chk("R4", rv, mdl[DEPTH-1]);
    wr(7, 8'hEE); mdl[DEPTH-1] = 8'hEE;
    wr(7, 8'hEF); mdl[DEPTH-1] = 8'hEF;
    drain_check("R4");

    // R5 rewind mid-stream
    rd(2, rv);
    wr(7, 8'h31); wr(7, 8'h32); wr(7, 8'h33);
    mdl[0] = 8'h31; mdl[1] = 8'h32; mdl[2] = 8'h33;
    rd(2, rv);
    rd(7, rv); chk("R5", rv, 8'h31);
    rd(2, rv);
    rd(7, rv); chk("R5", rv, 8'h31);

    // R6 count register
    wr(5, 8'h15); rd(5, rv); chk("R6", rv, 8'h15);
    @(negedge clk); eng_cnt_we = 1; eng_cnt_val = 8'h20;
    @(negedge clk); eng_cnt_we = 0;
    rd(5, rv); chk("R6", rv, 8'h20);
    @(negedge clk);
    reg_addr = 4'd5; reg_wdata = 8'h11; reg_wr = 1; eng_cnt_we = 1; eng_cnt_val = 8'h22;
    @(negedge clk); reg_wr = 0; eng_cnt_we = 0;
    rd(5, rv); chk("R6", rv, 8'h22);

    // R10 length clamp sweep
    for (int c = 0; c <= 40; c++) begin
      wr(5, c); chk("R10", eng_len, exp_len(c));
    end
    wr(5, 255); chk("R10", eng_len, DEPTH);

    // R8 transmit sweep over all lengths
    for (int L = 1; L <= DEPTH; L++) begin
      wr(5, L);
      estart();
      for (int i = 0; i < L; i++) begin
        @(negedge clk);
        #1;
        chk("R8", eng_tx_data, mdl[i]);
        chk("R8", eng_last, (i == L - 1) ? 1 : 0);
        chk("R8", eng_done, 0);
        eng_pop = 1;
        @(negedge clk); eng_pop = 0;
      end
      #1 chk("R8", eng_done, 1);
      @(negedge clk); eng_pop = 1;
      @(negedge clk); eng_pop = 0;
      #1 chk("R8", eng_done, 1);
    end

    // R9 receive with overflow pushes dropped
    for (int L = 1; L <= 6; L++) begin
      wr(5, L);
      estart();
      for (int i = 0; i < L + 2; i++) begin
        @(negedge clk);
        eng_push = 1; eng_rx_data = 8'(pat(i + L, 53));
        if (i < L) mdl[i] = 8'(pat(i + L, 53));
        @(negedge clk); eng_push = 0;
      end
      #1 chk("R9", eng_done, 1);
      drain_check("R9");
    end

    // R7 single holding register mode
    wr(13, 8'h00);
    rd(2, rv);
    wr(7, 8'hA1); wr(7, 8'hB2);
    mdl[0] = 8'hB2;
    rd(7, rv); chk("R7", rv, 8'hB2);
    rd(7, rv); chk("R7", rv, 8'hB2);
    wr(13, 8'h02);
    drain_check("R7");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule